// File: doc/BRIEF.md
# Two-Wire Target Register Access Engine

This block is a two-wire serial bus target that runs entirely on a fast system clock. It takes raw SCL and SDA levels, synchronises them, and finds clock edges as well as start and stop conditions. It answers one of two 7-bit device addresses, chosen by a strap pin, and it pulls SDA low through an open-drain enable. It keeps a register pointer and turns bus traffic into single-cycle read and write strobes for an external register bank.

A write transaction loads the pointer from the first byte after the address. Every later byte becomes a write strobe. A read usually sets the pointer with a short write, then issues a repeated start and the read address. The engine then fetches one byte for each bus byte. The pointer steps forward only inside fixed address windows, and the last window wraps to 0x00. A general-call command can re-latch the strap pin, and can also reset the device. Writing the shutdown bit of the control register silences the engine until the next hardware reset.

The register interface carries no back-pressure. The bank must accept a write strobe in any cycle. It must also present the byte at `reg_addr_o` combinationally on `reg_rdata_i` whenever `reg_rd_o` is high.

Top module: `i2c_reg_engine`

## Requirements
- R1: After a start, the first byte is compared with the device address. That address is 7-bit 0x41 when the latched strap is 0 and 0x44 when it is 1, and bit 0 is R/W (1 = read). On a match, SDA is pulled low in the ninth clock. On a mismatch, SDA is never driven and no strobe is issued until the next start.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Bytes clocked without a preceding start get no acknowledge and cause no strobe.
- R3: In a write, the byte after the address loads the pointer. Each later byte is acknowledged and gives a one-cycle `reg_wr_o` with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte.
- R4: After a read address, bytes are driven MSB first. There is exactly one `reg_rd_o` pulse before each byte. A master acknowledge continues the read, and a master no-acknowledge ends it with SDA released.
- R5: The pointer advances after each byte written or read only while it lies in 0x00–0x01, 0x08–0x09 or 0x10–0x12. From 0x12 it wraps to 0x00. At any other address it stays fixed.
- R6: General call (first byte 0x00) is acknowledged along with its command byte. Command 0x04 re-latches the strap. Command 0x06 re-latches the strap, pulses `dev_rst_o` for one cycle and clears the pointer to 0x00. Every other command changes nothing.
- R7: The strap is latched just after reset. Later changes on `addr_pin_i` have no effect until a general-call re-latch.
- R8: A data byte written to address 0x04 with bit 6 set is still stored and acknowledged. From the end of its acknowledge, SDA is never driven and no strobe is issued until `rst_n` is asserted.
- R9: `sda_oe_o` changes only after a detected SCL falling edge, or when a start or stop is detected.
- R10: During and right after reset, `sda_oe_o`, `reg_wr_o`, `reg_rd_o` and `dev_rst_o` are 0 and `reg_addr_o` is 0x00.
- R11: The pointer keeps its value across stop and repeated start. A read that sends no register byte continues from the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| addr_pin_i | input | 1 | Strap selecting the device address |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_addr_o | output | 8 | Register pointer |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 8 | Write data, valid with `reg_wr_o` |
| reg_rd_o | output | 1 | One-cycle register fetch strobe |
| reg_rdata_i | input | 8 | Bank data for `reg_addr_o` |
| dev_rst_o | output | 1 | One-cycle reset request from general call |

## Verification
Every bus edge reaches the control logic through two synchroniser flops and an edge register. A strobe, or a change on `sda_oe_o`, therefore appears in the third system clock after the SCL edge that causes it, and the pointer advances one clock after a strobe. The bench drives each SCL or SDA level on a falling system-clock edge and holds it for six clocks before the next bus event. It reads acknowledges and read data in the middle of the SCL-high phase, and checks the bank contents only after the stop. Every check is therefore sampled well after the three-clock latency and well before the next edge.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 4;

  localparam logic [6:0]        DEV_ADDR_LO    = 7'h41;
  localparam logic [6:0]        DEV_ADDR_HI    = 7'h44;
  localparam logic [DATA_W-1:0] GC_ADDR_BYTE   = 8'h00;
  localparam logic [DATA_W-1:0] GC_CMD_RESET   = 8'h06;
  localparam logic [DATA_W-1:0] GC_CMD_RELATCH = 8'h04;
  localparam logic [ADDR_W-1:0] CTRL_ADDR      = 8'h04;
  localparam int                SHDN_BIT       = 6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RX_ADDR, ST_RX_BYTE, ST_ACK_PEND, ST_ACK_HOLD,
    ST_TX_NEXT, ST_TX, ST_TX_ACK, ST_IGNORE, ST_OFF
  } eng_state_e;

  typedef enum logic [1:0] {PH_REG, PH_DATA, PH_GC, PH_DONE} rx_phase_e;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_i,
  output logic [N-1:0] pins_o,
  output logic [N-1:0] pins_prev_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-1:0], pins_i[g]};
    end
    assign pins_o[g]      = chain_q[STAGES-1];
    assign pins_prev_o[g] = chain_q[STAGES];
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic scl_now,
  input  logic scl_old,
  input  logic sda_now,
  input  logic sda_old,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_steady_hi;
  assign scl_steady_hi = scl_now & scl_old;
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_steady_hi & sda_old & ~sda_now;
  assign stop_det  = scl_steady_hi & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_ptr_next.sv
module i2c_ptr_next
  import i2c_eng_pkg::*;
#(
  parameter int                            NUM_RANGES = 3,
  parameter logic [NUM_RANGES*ADDR_W-1:0]  RANGE_LO   = {8'h10, 8'h08, 8'h00},
  parameter logic [NUM_RANGES*ADDR_W-1:0]  RANGE_HI   = {8'h12, 8'h09, 8'h01},
  parameter logic [ADDR_W-1:0]             LAST_ADDR  = 8'h12
) (
  input  logic [ADDR_W-1:0] ptr_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [NUM_RANGES-1:0] hit;

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_range
    logic [ADDR_W-1:0] lo, span, off;
    assign lo     = RANGE_LO[g*ADDR_W +: ADDR_W];
    assign span   = RANGE_HI[g*ADDR_W +: ADDR_W] - lo;
    assign off    = ptr_i - lo;
    assign hit[g] = (off <= span);
  end

  always_comb begin
    if (!(|hit))               ptr_o = ptr_i;
    else if (ptr_i == LAST_ADDR) ptr_o = '0;
    else                       ptr_o = ptr_i + 1'b1;
  end
endmodule

// File: rtl/i2c_reg_engine.sv
module i2c_reg_engine
  import i2c_eng_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_pin_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              dev_rst_o
);
  logic [1:0] pins_s, pins_p;
  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_pin_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_i      ({scl_i, sda_i}),
    .pins_o      (pins_s),
    .pins_prev_o (pins_p)
  );

  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];
  assign scl_p = pins_p[1];
  assign sda_p = pins_p[0];

  i2c_cond_detect u_cond (
    .scl_now   (scl_s),
    .scl_old   (scl_p),
    .sda_now   (sda_s),
    .sda_old   (sda_p),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  logic [ADDR_W-1:0] ptr_q, ptr_nx;

  i2c_ptr_next u_ptr (
    .ptr_i (ptr_q),
    .ptr_o (ptr_nx)
  );

  eng_state_e        state_q;
  rx_phase_e         phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [6:0]        shreg_q;
  logic [DATA_W-1:0] txsh_q, wdata_q, rx_byte;
  logic              ack_en_q, rw_q, shut_pend_q;
  logic              addr_lat_q, lat_done_q;
  logic              sda_oe_q, wr_q, rd_q, adv_q, devrst_q;
  logic [6:0]        dev_addr;

  assign rx_byte  = {shreg_q, sda_s};
  assign dev_addr = addr_lat_q ? DEV_ADDR_HI : DEV_ADDR_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_REG;
      cnt_q       <= '0;
      shreg_q     <= '0;
      txsh_q      <= '0;
      wdata_q     <= '0;
      ack_en_q    <= 1'b0;
      rw_q        <= 1'b0;
      shut_pend_q <= 1'b0;
      addr_lat_q  <= 1'b0;
      lat_done_q  <= 1'b0;
      sda_oe_q    <= 1'b0;
      wr_q        <= 1'b0;
      rd_q        <= 1'b0;
      adv_q       <= 1'b0;
      devrst_q    <= 1'b0;
      ptr_q       <= '0;
    end else begin
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      adv_q    <= 1'b0;
      devrst_q <= 1'b0;
      if (!lat_done_q) begin
        addr_lat_q <= addr_pin_i;
        lat_done_q <= 1'b1;
      end
      if (adv_q) ptr_q  <= ptr_nx;
      if (rd_q)  txsh_q <= reg_rdata_i;

      if (state_q == ST_OFF) begin
        sda_oe_q <= 1'b0;
      end else if (start_det) begin
        state_q  <= ST_RX_ADDR;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
      end else if (stop_det) begin
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        case (state_q)
          ST_RX_ADDR, ST_RX_BYTE: begin
            if (scl_rise) begin
              shreg_q <= rx_byte[6:0];
              cnt_q   <= cnt_q + 4'd1;
              if (cnt_q == 4'd7) begin
                state_q <= ST_ACK_PEND;
                if (state_q == ST_RX_ADDR) begin
                  if (rx_byte[7:1] == dev_addr) begin
                    ack_en_q <= 1'b1;
                    rw_q     <= rx_byte[0];
                    phase_q  <= PH_REG;
                  end else if (rx_byte == GC_ADDR_BYTE) begin
                    ack_en_q <= 1'b1;
                    rw_q     <= 1'b0;
                    phase_q  <= PH_GC;
                  end else begin
                    ack_en_q <= 1'b0;
                  end
                end else begin
                  ack_en_q <= 1'b1;
                  case (phase_q)
                    PH_REG: begin
                      ptr_q   <= rx_byte;
                      phase_q <= PH_DATA;
                    end
                    PH_DATA: begin
                      wr_q    <= 1'b1;
                      adv_q   <= 1'b1;
                      wdata_q <= rx_byte;
                      if (ptr_q == CTRL_ADDR && rx_byte[SHDN_BIT]) shut_pend_q <= 1'b1;
                    end
                    PH_GC: begin
                      phase_q <= PH_DONE;
                      if (rx_byte == GC_CMD_RESET) begin
                        devrst_q   <= 1'b1;
                        ptr_q      <= '0;
                        addr_lat_q <= addr_pin_i;
                      end else if (rx_byte == GC_CMD_RELATCH) begin
                        addr_lat_q <= addr_pin_i;
                      end
                    end
                    default: ack_en_q <= 1'b0;
                  endcase
                end
              end
            end
          end
          ST_ACK_PEND: begin
            if (scl_fall) begin
              if (ack_en_q) begin
                sda_oe_q <= 1'b1;
                state_q  <= ST_ACK_HOLD;
              end else begin
                state_q  <= ST_IGNORE;
              end
            end
          end
          ST_ACK_HOLD: begin
            if (scl_rise && rw_q) begin
              rd_q    <= 1'b1;
              state_q <= ST_TX_NEXT;
            end else if (scl_fall) begin
              sda_oe_q <= 1'b0;
              cnt_q    <= '0;
              state_q  <= shut_pend_q ? ST_OFF : ST_RX_BYTE;
            end
          end
          ST_TX_NEXT: begin
            if (scl_fall) begin
              sda_oe_q <= ~txsh_q[7];
              cnt_q    <= '0;
              state_q  <= ST_TX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 4'd1;
              if (cnt_q == 4'd7) adv_q <= 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_TX_ACK;
              end else begin
                sda_oe_q <= ~txsh_q[6];
                txsh_q   <= {txsh_q[6:0], 1'b0};
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              if (!sda_s) begin
                rd_q    <= 1'b1;
                state_q <= ST_TX_NEXT;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = sda_oe_q;
  assign reg_addr_o  = ptr_q;
  assign reg_wr_o    = wr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_rd_o    = rd_q;
  assign dev_rst_o   = devrst_q;

  // R9
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_q != $past(sda_oe_q)) |-> $past(scl_fall || start_det || stop_det));

  // R8
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF) |=> (state_q == ST_OFF && !sda_oe_q && !wr_q && !rd_q));

  // R1
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !sda_oe_q);

  // R3
  wr_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> $past(scl_rise));

  // R4
  rd_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |-> ($past(scl_rise) && !wr_q));

  // R6
  devrst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    devrst_q |=> !devrst_q);
endmodule

// File: tb/i2c_reg_engine_tb.sv
module i2c_reg_engine_tb;
  localparam int Q = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, m_scl, m_sda_low, addr_pin;
  logic       sda_oe, reg_wr, reg_rd, dev_rst;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       sda_line;

  assign sda_line = !(m_sda_low || sda_oe);

  i2c_reg_engine u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (m_scl),
    .sda_i       (sda_line),
    .addr_pin_i  (addr_pin),
    .sda_oe_o    (sda_oe),
    .reg_addr_o  (reg_addr),
    .reg_wr_o    (reg_wr),
    .reg_wdata_o (reg_wdata),
    .reg_rd_o    (reg_rd),
    .reg_rdata_i (reg_rdata),
    .dev_rst_o   (dev_rst)
  );

  // register bank model
  logic [255:0] wrote;
  logic [7:0]   wdat [256];
  int n_wr = 0, n_rd = 0, n_devrst = 0, n_r9 = 0;

  function automatic logic [7:0] pat(input logic [7:0] a);
    return a * 8'd7 + 8'd3;
  endfunction

  assign reg_rdata = wrote[reg_addr] ? wdat[reg_addr] : pat(reg_addr);

  always @(posedge clk) begin
    if (!rst_n) wrote <= '0;
    else if (reg_wr) begin
      wrote[reg_addr] <= 1'b1;
      wdat[reg_addr]  <= reg_wdata;
    end
    if (reg_wr)  n_wr     <= n_wr + 1;
    if (reg_rd)  n_rd     <= n_rd + 1;
    if (dev_rst) n_devrst <= n_devrst + 1;
  end

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && m_scl) n_r9 <= n_r9 + 1;
    prev_oe <= sda_oe;
  end

  function automatic logic [7:0] bank_at(input logic [7:0] a);
    return wrote[a] ? wdat[a] : pat(a);
  endfunction

  // pointer step computed from the requirement text (R5)
  function automatic logic [7:0] nxt(input logic [7:0] a);
    if (a == 8'h12) return 8'h00;
    if (a == 8'h00 || a == 8'h01 || a == 8'h08 || a == 8'h09 || a == 8'h10 || a == 8'h11)
      return a + 8'd1;
    return a;
  endfunction

  logic [7:0] exp_bank [256];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  int n_chk = 0, n_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; wt(Q);
    m_scl = 1'b1;     wt(Q);
    m_sda_low = 1'b1; wt(Q);
    m_scl = 1'b0;     wt(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wt(Q);
    m_scl = 1'b1;     wt(Q);
    m_sda_low = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = !b[i]; wt(Q);
      m_scl = 1'b1;      wt(2*Q);
      m_scl = 1'b0;      wt(Q);
    end
    m_sda_low = 1'b0; wt(Q);
    m_scl = 1'b1;     wt(Q);
    ack = !sda_line;  wt(Q);
    m_scl = 1'b0;     wt(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wt(Q);
      m_scl = 1'b1; wt(Q);
      b[i] = sda_line; wt(Q);
      m_scl = 1'b0;
    end
    wt(Q);
    m_sda_low = mack; wt(Q);
    m_scl = 1'b1;     wt(2*Q);
    m_scl = 1'b0;     wt(Q);
    m_sda_low = 1'b0;
  endtask

  task automatic do_write(input logic [6:0] dev, input logic [7:0] ra, input int len,
                          output logic a_ack, output int n_ack);
    logic k;
    n_ack = 0;
    bus_start();
    send_byte({dev, 1'b0}, a_ack);
    send_byte(ra, k);
    if (k) n_ack++;
    for (int i = 0; i < len; i++) begin
      send_byte(wbuf[i], k);
      if (k) n_ack++;
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] dev, input logic set_ptr, input logic [7:0] ra,
                         input int len, output logic a_ack);
    logic k;
    logic [7:0] b;
    bus_start();
    if (set_ptr) begin
      send_byte({dev, 1'b0}, k);
      send_byte(ra, k);
      bus_start();
    end
    send_byte({dev, 1'b1}, a_ack);
    for (int i = 0; i < len; i++) begin
      recv_byte(b, (i != len - 1));
      rbuf[i] = b;
    end
    bus_stop();
  endtask

  task automatic do_gc(input logic [7:0] cmd, output logic a1, output logic a2);
    bus_start();
    send_byte(8'h00, a1);
    send_byte(cmd, a2);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
    $finish;
  end

  initial begin
    logic a, k1, k2;
    int na, w0, r0, d0;
    logic [7:0] ptr;
    for (int i = 0; i < 256; i++) exp_bank[i] = pat(i[7:0]);
    rst_n = 1'b0; m_scl = 1'b1; m_sda_low = 1'b0; addr_pin = 1'b0;
    wt(10);
    check("R10 sda_oe", sda_oe, 0);
    check("R10 strobes", {reg_wr, reg_rd, dev_rst}, 0);
    check("R10 pointer", reg_addr, 8'h00);
    rst_n = 1'b1;
    wt(4);
    check("R10 after release", {sda_oe, reg_wr, reg_rd, dev_rst, reg_addr}, 0);

    // R2: byte with no start
    m_scl = 1'b0; wt(Q);
    send_byte(8'h82, a);
    check("R2 no start no ack", a, 0);
    m_scl = 1'b1; wt(2*Q);

    // R3: write two bytes at 0x10
    w0 = n_wr;
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    do_write(7'h41, 8'h10, 2, a, na);
    check("R1 addr ack low strap", a, 1);
    check("R3 byte acks", na, 3);
    check("R3 strobe count", n_wr - w0, 2);
    check("R3 data at 0x10", bank_at(8'h10), 8'hA5);
    check("R5 data at 0x11", bank_at(8'h11), 8'h5A);
    exp_bank[8'h10] = 8'hA5; exp_bank[8'h11] = 8'h5A;

    // R1: wrong address, then data
    w0 = n_wr;
    wbuf[0] = 8'h11;
    do_write(7'h44, 8'h20, 1, a, na);
    check("R1 mismatch no ack", a, 0);
    check("R1 mismatch bytes no ack", na, 0);
    check("R1 mismatch no strobe", n_wr - w0, 0);

    // R4/R5: read across the wrap
    r0 = n_rd;
    do_read(7'h41, 1'b1, 8'h12, 3, a);
    check("R4 read addr ack", a, 1);
    check("R4 byte0 at 0x12", rbuf[0], exp_bank[8'h12]);
    check("R5 wrap byte at 0x00", rbuf[1], exp_bank[8'h00]);
    check("R5 byte at 0x01", rbuf[2], exp_bank[8'h01]);
    check("R4 one fetch per byte", n_rd - r0, 3);

    // R5: fixed address
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
    do_write(7'h41, 8'h30, 3, a, na);
    check("R5 fixed last value", bank_at(8'h30), 8'h03);
    check("R5 fixed neighbour", bank_at(8'h31), exp_bank[8'h31]);
    exp_bank[8'h30] = 8'h03;

    // R11: pointer retained
    do_write(7'h41, 8'h08, 0, a, na);
    do_read(7'h41, 1'b0, 8'h00, 1, a);
    check("R11 read from kept pointer", rbuf[0], exp_bank[8'h08]);

    // R7: strap change ignored
    addr_pin = 1'b1; wt(Q);
    do_write(7'h41, 8'h09, 0, a, na);
    check("R7 old address still acks", a, 1);
    do_write(7'h44, 8'h09, 0, a, na);
    check("R7 new address not yet", a, 0);

    // R6: relatch
    d0 = n_devrst;
    do_gc(8'h04, k1, k2);
    check("R6 gc acks", {k1, k2}, 2'b11);
    do_write(7'h44, 8'h09, 0, a, na);
    check("R6 relatched high acks", a, 1);
    do_write(7'h41, 8'h09, 0, a, na);
    check("R6 old address dropped", a, 0);
    check("R6 relatch no reset", n_devrst - d0, 0);

    // R6: other command ignored
    addr_pin = 1'b0; wt(Q);
    do_gc(8'h33, k1, k2);
    check("R6 other cmd acks", {k1, k2}, 2'b11);
    do_write(7'h44, 8'h09, 0, a, na);
    check("R6 other cmd no relatch", a, 1);
    check("R6 other cmd no reset", n_devrst - d0, 0);

    // R6: reset command
    do_gc(8'h06, k1, k2);
    check("R6 reset pulse", n_devrst - d0, 1);
    do_read(7'h41, 1'b0, 8'h00, 1, a);
    check("R6 relatched low acks", a, 1);
    check("R6 pointer cleared", rbuf[0], exp_bank[8'h00]);

    // random traffic (R3, R4, R5)
    void'($urandom(32'h5EED_0042));
    for (int it = 0; it < 20; it++) begin
      logic [7:0] starts [9];
      logic [7:0] sa;
      int len;
      starts[0] = 8'h00; starts[1] = 8'h01; starts[2] = 8'h02; starts[3] = 8'h08;
      starts[4] = 8'h09; starts[5] = 8'h10; starts[6] = 8'h11; starts[7] = 8'h12;
      starts[8] = 8'h30;
      sa  = starts[$urandom % 9];
      len = 1 + int'($urandom % 4);
      ptr = sa;
      for (int i = 0; i < len; i++) begin
        wbuf[i] = 8'($urandom);
        exp_bank[ptr] = wbuf[i];
        ptr = nxt(ptr);
      end
      do_write(7'h41, sa, len, a, na);
      check("R3 random write acks", {a, 8'(na)}, {1'b1, 8'(len + 1)});
      r0 = n_rd;
      do_read(7'h41, 1'b1, sa, len, a);
      ptr = sa;
      for (int i = 0; i < len; i++) begin
        check("R5 random readback", rbuf[i], exp_bank[ptr]);
        ptr = nxt(ptr);
      end
      check("R4 random fetch count", n_rd - r0, len);
    end

    // R8: shutdown
    w0 = n_wr;
    wbuf[0] = 8'h40;
    do_write(7'h41, 8'h04, 1, a, na);
    check("R8 shutdown byte acked", {a, 8'(na)}, {1'b1, 8'd2});
    check("R8 shutdown byte stored", bank_at(8'h04), 8'h40);
    w0 = n_wr;
    wbuf[0] = 8'h77;
    do_write(7'h41, 8'h10, 1, a, na);
    check("R8 silent after shutdown", {a, 8'(na)}, 0);
    do_gc(8'h06, k1, k2);
    check("R8 gc ignored", {k1, k2}, 0);
    check("R8 no strobe", n_wr - w0, 0);
    rst_n = 1'b0; wt(4); rst_n = 1'b1; wt(4);
    do_write(7'h41, 8'h10, 0, a, na);
    check("R8 reset restores", a, 1);

    check("R9 sda changes only with scl low", n_r9, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule